// File: doc/BRIEF.md
# Keyed Row Erase/Program Sequencer

This block controls erase and program operations on a nonvolatile program-memory array. Software reaches it through a small register port. It has a control register, a key register, an 8-bit upper address register and a 16-bit lower address register. A destructive operation can start only when two conditions hold. First, a two-value unlock key must have been written to the key register in the required order with no other register write between the two values. Second, the very next write must set the start bit of the control register. Any other start attempt is refused, and the refusal is recorded in a sticky error bit.

The address registers can also be loaded by a side port. When a table-write operation occurs, it copies its page value into the upper register and its offset into the lower register in one cycle. A dummy table write can therefore set up the erase target. An accepted operation sends one command pulse with a row-aligned address to the array. The block then stays busy for a fixed number of cycles, which depends on the operation kind. During that time the processor is stalled. When the busy period ends, a one-cycle resume pulse tells the processor that execution can continue.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000 and both address registers read 0. `busy` and `resume` are 0 and the key state is cleared, so a start written straight after reset is refused.
- R2: The register select values are 0 for control, 1 for key, 2 for upper address and 3 for lower address. The upper address register keeps only bits 7:0 and reads back zero-extended. The lower address register keeps all 16 bits. The key register always reads 0.
- R3: A write of 0x0055 to the key register, then a write of 0x00AA to the key register, then a control write with bit 15 set starts an operation. This holds only if the control fields are valid.
- R4: Any bus write that is not the expected next key value clears the key state. This includes a wrong key value, a repeated first value, the values in reverse order, or a write to another register. A start attempt that is not immediately preceded by a complete key does nothing and sets the error bit (control bit 13).
- R5: The control fields are bit 14 (write enable) and bits 6:0 (operation code). Code 0x41 with enable set selects a row erase, so 0x4041 plus the start bit gives 0xC041. Code 0x01 with enable set selects a row program. A keyed start with enable clear or any other code issues no command and sets the error bit.
- R6: In the cycle after an accepted start, exactly one of `erase_cmd` or `prog_cmd` pulses for one cycle. At the same time, `row_addr` carries the 24-bit address {upper, lower} shifted right by 6. The low 6 address bits are therefore ignored.
- R7: A `tw_valid` cycle loads `tw_page` into the upper register and `tw_offset` into the lower register. If a bus write to an address register falls in the same cycle, the table write takes priority.
- R8: The control register reads 0xC041 (start bit set) and `busy` is high from the cycle after the accepted start, for exactly ERASE_CYCLES cycles for an erase or PROG_CYCLES cycles for a program. After that the start bit clears itself.
- R9: `resume` is high for exactly one cycle, in the first cycle after `busy` falls.
- R10: While `busy` is high, bus writes and table writes have no effect on any register.
- R11: When an operation completes the key state is cleared, so a start without a fresh key is refused.
- R12: An accepted start clears the error bit. A control write with bit 15 and bit 13 both clear also clears the error bit. A control write can never set the error bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| tw_valid | input | 1 | Table-write capture strobe |
| tw_page | input | 8 | Page captured into the upper address register |
| tw_offset | input | 16 | Offset captured into the lower address register |
| erase_cmd | output | 1 | One-cycle row erase command to the array |
| prog_cmd | output | 1 | One-cycle row program command to the array |
| row_addr | output | 18 | Row address that goes with a command |
| busy | output | 1 | Operation in progress; the processor is stalled |
| resume | output | 1 | One-cycle pulse after `busy` ends |

## Verification
The bench targets broken key sequences: a repeated first value, a reversed order, and an unrelated register write slipped between the two values. A design that checked only for the presence of the values would start an erase that should have been refused. It drives unaligned addresses and compares `row_addr` against the shifted address. An address that was not truncated would show up as a wrong row. It counts the busy cycles and checks the resume pulse, which catches off-by-one timers. It writes registers during the busy period, which exposes a design that lets the erase target move mid-operation. Finally it attempts starts right after completion and with invalid control fields, which catches a key that stays armed too long.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    localparam int DATA_W = 16;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_KEY  = 2'd1;
    localparam logic [1:0] SEL_AHI  = 2'd2;
    localparam logic [1:0] SEL_ALO  = 2'd3;

    localparam logic [DATA_W-1:0] KEY_STEP1 = 16'h0055;
    localparam logic [DATA_W-1:0] KEY_STEP2 = 16'h00AA;

    localparam int START_BIT = 15;
    localparam int WREN_BIT  = 14;
    localparam int ERR_BIT   = 13;

    localparam logic [6:0] OPC_ROW_ERASE = 7'h41;
    localparam logic [6:0] OPC_ROW_PROG  = 7'h01;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic       start;
        logic       wren;
        logic       err;
        logic [6:0] opc;
    } ctrl_t;

    function automatic op_kind_e decode_op(logic wren, logic [6:0] opc);
        if (!wren) return OP_NONE;
        case (opc)
            OPC_ROW_ERASE: return OP_ERASE;
            OPC_ROW_PROG:  return OP_PROG;
            default:       return OP_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        return {c.start, c.wren, c.err, 6'b000000, c.opc};
    endfunction

endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
    import nvm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear_i,
    output logic              armed_o
);

    key_state_e state_q, state_d;

    logic key_wr;
    assign key_wr = wr_en && (wr_sel == SEL_KEY);

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = KEY_IDLE;
        end else if (wr_en) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (key_wr && wr_data == KEY_STEP1) ? KEY_HALF  : KEY_IDLE;
                KEY_HALF:  state_d = (key_wr && wr_data == KEY_STEP2) ? KEY_ARMED : KEY_IDLE;
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign armed_o = (state_q == KEY_ARMED);

    AST_ARM_ONLY_FROM_HALF: assert property (@(posedge clk) disable iff (rst)
        (state_q == KEY_ARMED && $past(state_q) != KEY_ARMED) |-> $past(state_q) == KEY_HALF); // R3

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == KEY_ARMED && $past(wr_en)) |-> state_q == KEY_IDLE); // R4

endmodule

// File: rtl/nvm_addr_regs.sv
module nvm_addr_regs
    import nvm_seq_pkg::*;
#(
    parameter int AHI_W = 8,
    parameter int ALO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tw_valid,
    input  logic [AHI_W-1:0]  tw_page,
    input  logic [ALO_W-1:0]  tw_offset,
    output logic [AHI_W-1:0]  ahi_o,
    output logic [ALO_W-1:0]  alo_o
);

    logic [AHI_W-1:0] ahi_q;
    logic [ALO_W-1:0] alo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ahi_q <= '0;
            alo_q <= '0;
        end else if (!lock_i) begin
            if (tw_valid) begin
                ahi_q <= tw_page;
                alo_q <= tw_offset;
            end else if (wr_en && wr_sel == SEL_AHI) begin
                ahi_q <= wr_data[AHI_W-1:0];
            end else if (wr_en && wr_sel == SEL_ALO) begin
                alo_q <= wr_data[ALO_W-1:0];
            end
        end
    end

    assign ahi_o = ahi_q;
    assign alo_o = alo_q;

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(lock_i) |-> ($stable(ahi_q) && $stable(alo_q))); // R10

    AST_TW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ($past(tw_valid) && !$past(lock_i)) |-> (ahi_q == $past(tw_page) && alo_q == $past(tw_offset))); // R7

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer
    import nvm_seq_pkg::*;
#(
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  op_kind_e op_i,
    output logic     busy_o,
    output logic     done_o,
    output logic     resume_o
);

    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             resume_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = (op_i == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    assign done_o   = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            resume_q <= done_o;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= load_val;
            end else if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o   = busy_q;
    assign resume_o = resume_q;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q); // R8

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q); // R10

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int AHI_W        = 8,
    parameter int ALO_W        = 16,
    parameter int ROW_LSB      = 6,
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_we,
    input  logic [1:0]                  bus_sel,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    input  logic                        tw_valid,
    input  logic [AHI_W-1:0]            tw_page,
    input  logic [ALO_W-1:0]            tw_offset,
    output logic                        erase_cmd,
    output logic                        prog_cmd,
    output logic [AHI_W+ALO_W-ROW_LSB-1:0] row_addr,
    output logic                        busy,
    output logic                        resume
);

    localparam int ADDR_W = AHI_W + ALO_W;
    localparam int ROW_W  = ADDR_W - ROW_LSB;

    logic              busy_w, done_w, resume_w, armed_w;
    logic              wr_ok, tw_ok;
    logic [AHI_W-1:0]  ahi_w;
    logic [ALO_W-1:0]  alo_w;
    logic [ADDR_W-1:0] addr_full;

    ctrl_t    ctrl_q;
    op_kind_e req_kind;
    logic     ctrl_wr, start_req, start_ok;

    logic             erase_q, prog_q;
    logic [ROW_W-1:0] row_q;

    assign wr_ok = bus_we && !busy_w;
    assign tw_ok = tw_valid && !busy_w;

    nvm_key_fsm u_key (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_sel  (bus_sel),
        .wr_data (bus_wdata),
        .clear_i (done_w),
        .armed_o (armed_w)
    );

    nvm_addr_regs #(.AHI_W(AHI_W), .ALO_W(ALO_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (busy_w),
        .wr_en     (wr_ok),
        .wr_sel    (bus_sel),
        .wr_data   (bus_wdata),
        .tw_valid  (tw_ok),
        .tw_page   (tw_page),
        .tw_offset (tw_offset),
        .ahi_o     (ahi_w),
        .alo_o     (alo_w)
    );

    assign ctrl_wr   = wr_ok && (bus_sel == SEL_CTRL);
    assign start_req = ctrl_wr && bus_wdata[START_BIT];
    assign req_kind  = decode_op(bus_wdata[WREN_BIT], bus_wdata[6:0]);
    assign start_ok  = start_req && armed_w && (req_kind != OP_NONE);

    nvm_busy_timer #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_ok),
        .op_i     (req_kind),
        .busy_o   (busy_w),
        .done_o   (done_w),
        .resume_o (resume_w)
    );

    assign addr_full = {ahi_w, alo_w};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.wren <= 1'b0;
            ctrl_q.err  <= 1'b0;
            ctrl_q.opc  <= '0;
            erase_q     <= 1'b0;
            prog_q      <= 1'b0;
            row_q       <= '0;
        end else begin
            erase_q <= start_ok && (req_kind == OP_ERASE);
            prog_q  <= start_ok && (req_kind == OP_PROG);
            if (start_ok) row_q <= addr_full[ADDR_W-1:ROW_LSB];
            if (ctrl_wr) begin
                ctrl_q.wren <= bus_wdata[WREN_BIT];
                ctrl_q.opc  <= bus_wdata[6:0];
                if (bus_wdata[START_BIT]) ctrl_q.err <= !start_ok;
                else                      ctrl_q.err <= ctrl_q.err & bus_wdata[ERR_BIT];
            end
        end
    end

    assign ctrl_q.start = busy_w;

    always_comb begin
        unique case (bus_sel)
            SEL_CTRL: bus_rdata = pack_ctrl(ctrl_q);
            SEL_KEY:  bus_rdata = '0;
            SEL_AHI:  bus_rdata = {{(DATA_W-AHI_W){1'b0}}, ahi_w};
            default:  bus_rdata = alo_w;
        endcase
    end

    assign erase_cmd = erase_q;
    assign prog_cmd  = prog_q;
    assign row_addr  = row_q;
    assign busy      = busy_w;
    assign resume    = resume_w;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_q, prog_q})); // R6

    AST_CMD_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (erase_q || prog_q) |-> busy_w); // R8

    AST_RESUME_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        resume_w |-> (!busy_w && $past(busy_w))); // R9

    AST_REFUSED_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        ($past(start_req) && !$past(start_ok)) |-> (ctrl_q.err && !busy_w)); // R4

endmodule

// File: tb/nvm_seq_ctrl_tb_top.sv
module nvm_seq_ctrl_tb_top;

    localparam int ERASE_N = 40;
    localparam int PROG_N  = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tw_valid = 1'b0;
    logic [7:0]  tw_page = '0;
    logic [15:0] tw_offset = '0;
    logic        erase_cmd, prog_cmd, busy, resume;
    logic [17:0] row_addr;

    int checks = 0;
    int fails  = 0;
    int n_erase = 0;
    int n_prog  = 0;
    logic [17:0] last_row = '0;

    always #10 clk = ~clk;

    nvm_seq_ctrl #(.ERASE_CYCLES(ERASE_N), .PROG_CYCLES(PROG_N)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tw_valid(tw_valid),
        .tw_page(tw_page), .tw_offset(tw_offset), .erase_cmd(erase_cmd),
        .prog_cmd(prog_cmd), .row_addr(row_addr), .busy(busy), .resume(resume)
    );

    // behavioural array side: record commands
    always @(posedge clk) begin
        if (!rst) begin
            if (erase_cmd) begin n_erase = n_erase + 1; last_row = row_addr; end
            if (prog_cmd)  begin n_prog  = n_prog + 1;  last_row = row_addr; end
        end
    end

    function automatic logic [17:0] exp_row(logic [7:0] hi, logic [15:0] lo);
        logic [23:0] full;
        full = {hi, lo};
        return full[23:6];
    endfunction

    function automatic logic [15:0] exp_ctrl(logic st, logic en, logic er, logic [6:0] opc);
        return {st, en, er, 6'b0, opc};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [15:0] d);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic tw(logic [7:0] p, logic [15:0] o);
        @(negedge clk);
        tw_valid = 1'b1; tw_page = p; tw_offset = o;
        @(negedge clk);
        tw_valid = 1'b0;
    endtask

    task automatic key();
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int e0, p0, n;
        logic [7:0]  hi;
        logic [15:0] lo;
        int unused_seed;
        unused_seed = $urandom(32'h5EED1234);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); chk("R1 ctrl", r, 16'h0000);
        rd(2'd2, r); chk("R1 ahi", r, 0);
        rd(2'd3, r); chk("R1 alo", r, 0);
        chk("R1 busy", {busy, resume}, 0);

        // R2 register map
        wr(2'd2, 16'h12A5); rd(2'd2, r); chk("R2 ahi width", r, 16'h00A5);
        wr(2'd3, 16'hBEEF); rd(2'd3, r); chk("R2 alo", r, 16'hBEEF);
        rd(2'd1, r); chk("R2 key reads 0", r, 0);

        // R1/R4 start straight after reset without key
        e0 = n_erase;
        wr(2'd0, 16'hC041); @(negedge clk);
        rd(2'd0, r); chk("R4 refused start", r, exp_ctrl(0, 1, 1, 7'h41));
        chk("R4 no cmd", n_erase - e0, 0);

        // R12 clear error
        wr(2'd0, 16'h6041); rd(2'd0, r); chk("R12 err cannot be set", r, exp_ctrl(0, 1, 1, 7'h41));
        wr(2'd0, 16'h4041); rd(2'd0, r); chk("R12 err cleared", r, exp_ctrl(0, 1, 0, 7'h41));

        // R3/R5/R6 valid erase, unaligned address; R10 writes during busy
        wr(2'd2, 16'h0001); wr(2'd3, 16'h2345);
        e0 = n_erase;
        key(); wr(2'd0, 16'hC041);
        rd(2'd0, r); chk("R8 start bit reads 1", r, exp_ctrl(1, 1, 0, 7'h41));
        @(negedge clk);
        chk("R3 erase issued", n_erase - e0, 1);
        chk("R6 row aligned", last_row, exp_row(8'h01, 16'h2345));
        wr(2'd2, 16'h0077); tw(8'h99, 16'h1111); wr(2'd0, 16'h0000);
        wait_idle();
        rd(2'd2, r); chk("R10 ahi locked", r, 16'h0001);
        rd(2'd3, r); chk("R10 alo locked", r, 16'h2345);
        rd(2'd0, r); chk("R10 ctrl locked", r, exp_ctrl(0, 1, 0, 7'h41));

        // R11 no start after completion without fresh key
        e0 = n_erase;
        wr(2'd0, 16'hC041); @(negedge clk);
        chk("R11 no reuse of key", n_erase - e0, 0);
        rd(2'd0, r); chk("R11 err set", r[13], 1);

        // R4 broken sequences
        e0 = n_erase;
        wr(2'd1, 16'h0055); wr(2'd3, 16'h2345); wr(2'd1, 16'h00AA); wr(2'd0, 16'hC041);
        wr(2'd1, 16'h00AA); wr(2'd1, 16'h0055); wr(2'd0, 16'hC041);
        wr(2'd1, 16'h0055); wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA); wr(2'd0, 16'hC041);
        key(); wr(2'd0, 16'h4041); wr(2'd0, 16'hC041);
        @(negedge clk);
        chk("R4 broken keys refused", n_erase - e0, 0);
        chk("R4 busy stays low", busy, 0);

        // R5 invalid fields with valid key
        e0 = n_erase; p0 = n_prog;
        key(); wr(2'd0, 16'h8041); rd(2'd0, r); chk("R5 wren clear refused", r, exp_ctrl(0, 0, 1, 7'h41));
        key(); wr(2'd0, 16'hC033); rd(2'd0, r); chk("R5 bad opcode refused", r, exp_ctrl(0, 1, 1, 7'h33));
        @(negedge clk);
        chk("R5 no cmd", (n_erase - e0) + (n_prog - p0), 0);

        // R7 table write, and priority over same-cycle bus write
        tw(8'h3C, 16'h1234);
        rd(2'd2, r); chk("R7 page", r, 16'h003C);
        rd(2'd3, r); chk("R7 offset", r, 16'h1234);
        @(negedge clk);
        tw_valid = 1'b1; tw_page = 8'h5A; tw_offset = 16'h0FC0;
        bus_we = 1'b1; bus_sel = 2'd3; bus_wdata = 16'hFFFF;
        @(negedge clk);
        tw_valid = 1'b0; bus_we = 1'b0;
        rd(2'd3, r); chk("R7 tw priority", r, 16'h0FC0);

        // R8/R9 program op timing, R12 successful start clears err
        p0 = n_prog;
        key(); wr(2'd0, 16'hC001);
        n = 0;
        for (int i = 0; i < 1000 && busy; i++) begin n++; @(negedge clk); end
        chk("R8 prog busy length", n, PROG_N);
        chk("R9 resume pulse", resume, 1);
        @(negedge clk);
        chk("R9 resume one cycle", resume, 0);
        chk("R6 prog issued", n_prog - p0, 1);
        chk("R6 prog row", last_row, exp_row(8'h5A, 16'h0FC0));
        rd(2'd0, r); chk("R12 err cleared by start", r, exp_ctrl(0, 1, 0, 7'h01));

        // R8 erase length
        key(); wr(2'd0, 16'hC041);
        n = 0;
        for (int i = 0; i < 1000 && busy; i++) begin n++; @(negedge clk); end
        chk("R8 erase busy length", n, ERASE_N);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int pat;
            logic is_erase;
            pat = int'($urandom % 4);
            is_erase = 1'($urandom % 2);
            hi = 8'($urandom); lo = 16'($urandom);
            if ($urandom % 2) tw(hi, lo);
            else begin wr(2'd2, {8'h00, hi}); wr(2'd3, lo); end
            e0 = n_erase; p0 = n_prog;
            case (pat)
                0: key();
                1: begin wr(2'd1, 16'h0056); wr(2'd1, 16'h00AA); end
                2: begin wr(2'd1, 16'h0055); wr(2'd1, 16'h0000); wr(2'd1, 16'h00AA); end
                default: begin wr(2'd1, 16'h00AA); wr(2'd1, 16'h0055); end
            endcase
            wr(2'd0, is_erase ? 16'hC041 : 16'hC001);
            @(negedge clk);
            if (pat == 0) begin
                chk("R3 rand accepted", is_erase ? (n_erase - e0) : (n_prog - p0), 1);
                chk("R6 rand row", last_row, exp_row(hi, lo));
            end else begin
                chk("R4 rand refused", (n_erase - e0) + (n_prog - p0), 0);
                rd(2'd0, r); chk("R4 rand err", r[13], 1);
            end
            wait_idle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule